// File: doc/BRIEF.md
# Four-Way Set-Associative Write-Back Data Cache

This block sits between a processor load/store port and a word-wide external memory port. It holds 8 KB as four ways of 128 lines, each line four 32-bit words. A lookup reads the four tags of one set at once. A store that hits is held in the cache and marked dirty, or is also written to memory, depending on the write policy. A miss stalls the processor by holding `cpu_ready` low. If the chosen victim is dirty, it is copied back to memory first. The line is then refilled word by word and the access is retried, so it hits.

A four-bit control register sets the behaviour: bit 0 enables the cache, bit 1 selects write-through, bit 2 locks ways 2 and 3 against replacement, and bit 3 flushes the cache. Victims are chosen by least-recently-used order within the set, and a free (invalid) way is always used first. Any address with bit 29 set is an uncached alias of the same memory word. So is every address while the cache is disabled. Such an access goes to memory as a single transfer.

The controller is a five-state machine:
- **IDLE**: the lookup and hit service.
- **WBACK**: dirty-line copy-back.
- **FILL**: line refill.
- **BYPASS**: uncached transfer.
- **WTHRU**: write-through store.

Its transitions are:
- IDLE→BYPASS on an uncached request.
- IDLE→WTHRU on a store hit in write-through mode.
- IDLE→WBACK on a miss with a dirty victim.
- IDLE→FILL on a miss with a clean victim.
- WBACK→FILL after the fourth copy-back word.
- FILL→IDLE after the fourth refill word.
- BYPASS→IDLE and WTHRU→IDLE on the memory acknowledge.

Top module: `dcache4w`

## Requirements
- R1: After reset, no memory request and no `cpu_ready` are issued until a processor request arrives, and every line is invalid.
- R2: A cached read miss issues four memory reads at the line base plus 0, 4, 8 and 12, in that order, and then returns the addressed word. Later accesses to that line complete with no memory traffic and with `cpu_ready` in the cycle of the request.
- R3: Address bits 10:4 select the set and bits 3:2 select the word within the line, so a second word of a filled line is returned from the cache.
- R4: The stored tag is address bits 28:11. Bits 31 and 30 take no part in the lookup, so an address that differs only in them hits the same line.
- R5: With bit 1 of the control register clear (write-back), a store hit updates only the cache and marks the line dirty. It issues no memory transfer.
- R6: Evicting a dirty line first writes its four words, in ascending order, to the address it came from. The refill follows, so memory then holds the stored data.
- R7: With control bit 1 set (write-through), a store hit updates the cache and issues exactly one memory write. `cpu_ready` is raised with that write's acknowledge.
- R8: A miss picks an invalid way if one exists. Otherwise it evicts the least recently used of the four ways in the set.
- R9: With control bit 2 set, only ways 0 and 1 are chosen as victims, so lines in ways 2 and 3 stay resident.
- R10: Writing control bit 3 invalidates every line in the following cycle without any memory write. The bit does not stay set, and no access is served in that cycle.
- R11: An access whose address bit 29 is 1 is done as one memory transfer at that address. It performs no lookup and no allocation, so it reads memory even while a dirty line for the same word is resident.
- R12: With control bit 0 clear, every access is done as a single memory transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 4 | Control value: bit0 enable, bit1 write-through, bit2 lock ways 2-3, bit3 flush |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| cpu_ready | output | 1 | Access completes in this cycle |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory transfer completes |

## Verification
The bench drives the cache with several access patterns. Repeated reads of one line separate a true hit from a silent refill, because a hit causes no memory traffic. Reads of addresses that differ only in the high tag bits, or only in the alias bit, separate tag aliasing from the uncached path. Five and more lines are driven into a single set in chosen orders, with and without the lock bit. This exposes the victim choice: a resident line's next access either costs four transfers or none. Stores followed by uncached reads of the same word show where the data actually lives under write-back, write-through, eviction and flush.

// File: rtl/dc_pkg.sv
package dc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WBACK,
        ST_FILL,
        ST_BYPASS,
        ST_WTHRU
    } dc_state_e;

    localparam int CFG_EN    = 0;
    localparam int CFG_WT    = 1;
    localparam int CFG_LOCK  = 2;
    localparam int CFG_FLUSH = 3;
endpackage

// File: rtl/dc_tags.sv
module dc_tags #(
    parameter int WAYS  = 4,
    parameter int SETS  = 128,
    parameter int TAG_W = 18
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(SETS)-1:0]     idx,
    input  logic [TAG_W-1:0]            tag,
    input  logic                        flush,
    input  logic                        fill_we,
    input  logic [$clog2(WAYS)-1:0]     fill_way,
    input  logic                        set_dirty,
    input  logic [$clog2(WAYS)-1:0]     dirty_way,
    output logic                        hit,
    output logic [$clog2(WAYS)-1:0]     hit_way,
    output logic [WAYS-1:0]             valid_vec,
    output logic [WAYS-1:0]             dirty_vec,
    output logic [WAYS-1:0][TAG_W-1:0]  set_tags
);
    localparam int WAY_W = $clog2(WAYS);

    logic [TAG_W-1:0] tag_q [WAYS][SETS];
    logic [SETS-1:0]  vld_q [WAYS];
    logic [SETS-1:0]  drt_q [WAYS];
    logic [WAYS-1:0]  match;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign valid_vec[w] = vld_q[w][idx];
        assign dirty_vec[w] = drt_q[w][idx];
        assign set_tags[w]  = tag_q[w][idx];
        assign match[w]     = vld_q[w][idx] && (tag_q[w][idx] == tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (match[w]) hit_way = WAY_W'(w);
    end
    assign hit = |match;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++) begin
                vld_q[w] <= '0;
                drt_q[w] <= '0;
            end
        end else if (flush) begin
            for (int w = 0; w < WAYS; w++) vld_q[w] <= '0;
        end else begin
            if (fill_we) begin
                vld_q[fill_way][idx] <= 1'b1;
                drt_q[fill_way][idx] <= 1'b0;
            end
            if (set_dirty) drt_q[dirty_way][idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_we) tag_q[fill_way][idx] <= tag;
    end
endmodule

// File: rtl/dc_lru.sv
module dc_lru #(
    parameter int WAYS = 4,
    parameter int SETS = 128
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(SETS)-1:0] idx,
    input  logic                    touch,
    input  logic [$clog2(WAYS)-1:0] touch_way,
    input  logic [WAYS-1:0]         valid_vec,
    input  logic                    lock,
    output logic [$clog2(WAYS)-1:0] victim
);
    localparam int WAY_W = $clog2(WAYS);
    localparam int AGE_W = $clog2(WAYS);

    logic [AGE_W-1:0] age_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= AGE_W'(w);
        end else if (touch) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age_q[idx][w] <= '0;
                else if (age_q[idx][w] < age_q[idx][touch_way])
                    age_q[idx][w] <= age_q[idx][w] + 1'b1;
            end
        end
    end

    always_comb begin
        logic             found;
        logic [AGE_W-1:0] best;
        victim = '0;
        found  = 1'b0;
        best   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if ((!lock || w < WAYS/2) && !valid_vec[w] && !found) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if ((!lock || w < WAYS/2) && age_q[idx][w] >= best) begin
                    best   = age_q[idx][w];
                    victim = WAY_W'(w);
                end
            end
        end
    end
endmodule

// File: rtl/dc_data.sv
module dc_data #(
    parameter int WAYS       = 4,
    parameter int SETS       = 128,
    parameter int LINE_WORDS = 4,
    parameter int DATA_W     = 32
) (
    input  logic                          clk,
    input  logic                          we,
    input  logic [$clog2(WAYS)-1:0]       w_way,
    input  logic [$clog2(SETS)-1:0]       w_idx,
    input  logic [$clog2(LINE_WORDS)-1:0] w_word,
    input  logic [DATA_W-1:0]             w_data,
    input  logic [$clog2(WAYS)-1:0]       a_way,
    input  logic [$clog2(SETS)-1:0]       a_idx,
    input  logic [$clog2(LINE_WORDS)-1:0] a_word,
    output logic [DATA_W-1:0]             a_data,
    input  logic [$clog2(WAYS)-1:0]       b_way,
    input  logic [$clog2(LINE_WORDS)-1:0] b_word,
    output logic [DATA_W-1:0]             b_data
);
    localparam int DEPTH = WAYS * SETS * LINE_WORDS;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[{w_way, w_idx, w_word}] <= w_data;
    end

    assign a_data = mem_q[{a_way, a_idx, a_word}];
    assign b_data = mem_q[{b_way, a_idx, b_word}];
endmodule

// File: rtl/dcache4w.sv
module dcache4w #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int WAYS       = 4,
    parameter int SETS       = 128,
    parameter int LINE_WORDS = 4,
    parameter int ALIAS_BIT  = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_wdata,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    import dc_pkg::*;

    localparam int WORD_W  = $clog2(LINE_WORDS);
    localparam int BYTE_W  = $clog2(DATA_W / 8);
    localparam int OFF_W   = WORD_W + BYTE_W;
    localparam int IDX_W   = $clog2(SETS);
    localparam int WAY_W   = $clog2(WAYS);
    localparam int TAG_LO  = OFF_W + IDX_W;
    localparam int TAG_W   = ALIAS_BIT - TAG_LO;
    localparam int ZERO_HI = ADDR_W - ALIAS_BIT;

    dc_state_e st_q, st_d;
    logic [WORD_W-1:0] cnt_q;
    logic [WAY_W-1:0]  vic_q;
    logic en_q, wt_q, lock_q, flush_q;

    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] word;
    logic [TAG_W-1:0]  tag;
    logic cacheable, lookup, last, hit, vic_dirty, store_hit, fill_step, fill_done;
    logic [WAY_W-1:0]  hit_way, victim;
    logic [WAYS-1:0]   valid_vec, dirty_vec;
    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    logic [DATA_W-1:0] hit_data, wb_data;
    logic [ADDR_W-1:0] fill_addr, wb_addr;

    assign idx       = cpu_addr[TAG_LO-1:OFF_W];
    assign word      = cpu_addr[OFF_W-1:BYTE_W];
    assign tag       = cpu_addr[ALIAS_BIT-1:TAG_LO];
    assign cacheable = en_q && !cpu_addr[ALIAS_BIT];
    assign lookup    = (st_q == ST_IDLE) && cpu_req && !flush_q && cacheable;
    assign last      = (cnt_q == WORD_W'(LINE_WORDS - 1));
    assign vic_dirty = valid_vec[victim] && dirty_vec[victim];
    assign store_hit = lookup && hit && cpu_we;
    assign fill_step = (st_q == ST_FILL) && mem_ack;
    assign fill_done = fill_step && last;
    assign fill_addr = {{ZERO_HI{1'b0}}, tag, idx, cnt_q, {BYTE_W{1'b0}}};
    assign wb_addr   = {{ZERO_HI{1'b0}}, set_tags[vic_q], idx, cnt_q, {BYTE_W{1'b0}}};

    dc_tags #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .idx(idx), .tag(tag), .flush(flush_q),
        .fill_we(fill_done), .fill_way(vic_q),
        .set_dirty(store_hit && !wt_q), .dirty_way(hit_way),
        .hit(hit), .hit_way(hit_way), .valid_vec(valid_vec),
        .dirty_vec(dirty_vec), .set_tags(set_tags)
    );

    dc_lru #(.WAYS(WAYS), .SETS(SETS)) u_lru (
        .clk(clk), .rst_n(rst_n), .idx(idx), .touch(lookup && hit),
        .touch_way(hit_way), .valid_vec(valid_vec), .lock(lock_q),
        .victim(victim)
    );

    dc_data #(.WAYS(WAYS), .SETS(SETS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_data (
        .clk(clk), .we(fill_step || store_hit),
        .w_way(fill_step ? vic_q : hit_way), .w_idx(idx),
        .w_word(fill_step ? cnt_q : word),
        .w_data(fill_step ? mem_rdata : cpu_wdata),
        .a_way(hit_way), .a_idx(idx), .a_word(word), .a_data(hit_data),
        .b_way(vic_q), .b_word(cnt_q), .b_data(wb_data)
    );

    // Control register; the flush request lives for a single cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0; wt_q <= 1'b0; lock_q <= 1'b0; flush_q <= 1'b0;
        end else begin
            flush_q <= cfg_we && cfg_wdata[CFG_FLUSH];
            if (cfg_we) begin
                en_q   <= cfg_wdata[CFG_EN];
                wt_q   <= cfg_wdata[CFG_WT];
                lock_q <= cfg_wdata[CFG_LOCK];
            end
        end
    end

    // State register with the word counter and latched victim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            vic_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE) vic_q <= victim;
            if (mem_ack && (st_q == ST_WBACK || st_q == ST_FILL))
                cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (cpu_req && !flush_q) begin
                    if (!cacheable)          st_d = ST_BYPASS;
                    else if (hit)            st_d = (cpu_we && wt_q) ? ST_WTHRU : ST_IDLE;
                    else if (vic_dirty)      st_d = ST_WBACK;
                    else                     st_d = ST_FILL;
                end
            end
            ST_WBACK:  if (mem_ack && last) st_d = ST_FILL;
            ST_FILL:   if (mem_ack && last) st_d = ST_IDLE;
            ST_BYPASS: if (mem_ack)         st_d = ST_IDLE;
            ST_WTHRU:  if (mem_ack)         st_d = ST_IDLE;
            default:                        st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = fill_addr;
        mem_wdata = cpu_wdata;
        cpu_ready = 1'b0;
        cpu_rdata = hit_data;
        unique case (st_q)
            ST_IDLE:   cpu_ready = lookup && hit && !(cpu_we && wt_q);
            ST_WBACK: begin
                mem_req = 1'b1; mem_we = 1'b1; mem_addr = wb_addr; mem_wdata = wb_data;
            end
            ST_FILL:   mem_req = 1'b1;
            ST_BYPASS: begin
                mem_req = 1'b1; mem_we = cpu_we; mem_addr = cpu_addr;
                cpu_rdata = mem_rdata; cpu_ready = mem_ack;
            end
            ST_WTHRU: begin
                mem_req = 1'b1; mem_we = 1'b1; mem_addr = cpu_addr; cpu_ready = mem_ack;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dcache4w_chk.sv
module dcache4w_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [3:0]  cfg_wdata,
    input logic        cpu_req,
    input logic [31:0] cpu_addr,
    input logic        cpu_ready,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic        mem_ack,
    input logic        en_q
);
    // R2: completion only answers an outstanding request
    a_r2_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req);

    // R6: a memory transfer keeps its address and direction until acknowledged
    a_r6_mem_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R10: the cycle after a flush write serves nothing and touches no memory
    a_r10_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_wdata[3] |=> !cpu_ready && !mem_req);

    // R11: an alias access only completes with a memory acknowledge
    a_r11_alias_mem: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_addr[29] && cpu_ready |-> mem_ack);

    // R12: with the cache off, completion comes from memory
    a_r12_off_mem: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q && cpu_ready |-> mem_ack);

    // R3: memory is addressed by whole words
    a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);
endmodule

bind dcache4w dcache4w_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .en_q(en_q)
);

// File: tb/dcache4w_test.sv
`timescale 1ns/1ps
module dcache4w_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_wdata = '0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int txn = 0;
    int wr_cnt = 0;
    logic [31:0] mem [4096];
    logic [31:0] log_q [16];

    always #2 clk = ~clk;

    dcache4w uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // Word memory: one-cycle acknowledge; address bits above 13 are ignored.
    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            log_q[txn % 16] <= mem_addr;
            txn <= txn + 1;
            if (mem_we) begin
                mem[mem_addr[13:2]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else mem_rdata <= mem[mem_addr[13:2]];
        end else mem_ack <= 1'b0;
    end

    function automatic logic [31:0] pat(input logic [31:0] a);
        return 32'h5A00_0000 | {20'b0, a[13:2]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [3:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                          output logic [31:0] rd);
        int n = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; rd = '0;
        while (1) begin
            #1;
            if (cpu_ready) begin rd = cpu_rdata; break; end
            @(negedge clk);
            n++;
            if (n > 200) begin
                chk("timeout", 32'd0, 32'd1);
                break;
            end
        end
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    // Read and return the number of memory transfers it cost.
    task automatic rd_cnt(input logic [31:0] a, output logic [31:0] d, output int cost);
        int t0 = txn;
        access(1'b0, a, '0, d);
        cost = txn - t0;
    endtask

    task automatic t_reset;
        #1;
        chk("R1 ready idle", {31'b0, cpu_ready}, 32'd0);
        chk("R1 mem idle", {31'b0, mem_req}, 32'd0);
    endtask

    task automatic t_fill;
        logic [31:0] d; int c, t0;
        cfg(4'h9);
        t0 = txn;
        rd_cnt(32'h0000_0138, d, c);
        chk("R1 empty after reset: miss cost", c, 4);
        chk("R2 refill data", d, pat(32'h138));
        for (int i = 0; i < 4; i++)
            chk("R2 ascending refill address", log_q[(t0 + i) % 16], 32'h130 + 4 * i);
        rd_cnt(32'h0000_013C, d, c);
        chk("R3 word select data", d, pat(32'h13C));
        chk("R2 hit no traffic", c, 0);
    endtask

    task automatic t_alias;
        logic [31:0] d; int c;
        rd_cnt(32'h8000_0134, d, c);
        chk("R4 bit31 alias hit", c, 0);
        chk("R4 bit31 alias data", d, pat(32'h134));
        rd_cnt(32'h4000_0130, d, c);
        chk("R4 bit30 alias hit", c, 0);
    endtask

    task automatic t_writeback;
        logic [31:0] d; int c, w0;
        rd_cnt(32'h0000_0204, d, c);
        w0 = txn;
        access(1'b1, 32'h0000_0204, 32'hDEAD_BEEF, d);
        chk("R5 store hit no traffic", txn - w0, 0);
        rd_cnt(32'h0000_0204, d, c);
        chk("R5 cached new value", d, 32'hDEAD_BEEF);
        rd_cnt(32'h2000_0204, d, c);
        chk("R11 alias single transfer", c, 1);
        chk("R5 memory still old", d, pat(32'h204));
        for (int k = 1; k < 4; k++) rd_cnt(32'h0000_0204 + k * 32'h800, d, c);
        w0 = wr_cnt;
        rd_cnt(32'h0000_2204, d, c);
        chk("R6 eviction cost", c, 8);
        chk("R6 eviction writes", wr_cnt - w0, 4);
        rd_cnt(32'h2000_0204, d, c);
        chk("R6 memory holds store", d, 32'hDEAD_BEEF);
    endtask

    task automatic t_lru;
        logic [31:0] d; int c;
        cfg(4'h9);
        for (int k = 0; k < 4; k++) rd_cnt(32'h50 + k * 32'h800, d, c);
        rd_cnt(32'h50, d, c);
        chk("R8 touch hit", c, 0);
        rd_cnt(32'h50 + 4 * 32'h800, d, c);
        chk("R8 fifth line miss", c, 4);
        rd_cnt(32'h50, d, c);
        chk("R8 recent line kept", c, 0);
        rd_cnt(32'h50 + 32'h800, d, c);
        chk("R8 oldest line evicted", c, 4);
    endtask

    task automatic t_lock;
        logic [31:0] d; int c;
        cfg(4'h9);
        for (int k = 0; k < 4; k++) rd_cnt(32'h90 + k * 32'h800, d, c);
        cfg(4'h5);
        for (int k = 4; k < 7; k++) rd_cnt(32'h90 + k * 32'h800, d, c);
        rd_cnt(32'h90 + 2 * 32'h800, d, c);
        chk("R9 way2 line kept", c, 0);
        rd_cnt(32'h90 + 3 * 32'h800, d, c);
        chk("R9 way3 line kept", c, 0);
    endtask

    task automatic t_flush;
        logic [31:0] d; int c, t0;
        cfg(4'h1);
        rd_cnt(32'h3A0, d, c);
        access(1'b1, 32'h3A0, 32'h1234_5678, d);
        t0 = txn;
        cfg(4'h9);
        chk("R10 no flush traffic", txn - t0, 0);
        rd_cnt(32'h2000_03A0, d, c);
        chk("R10 dirty data discarded", d, pat(32'h3A0));
        rd_cnt(32'h3A0, d, c);
        chk("R10 line invalid", c, 4);
        chk("R10 refill old data", d, pat(32'h3A0));
    endtask

    task automatic t_wthru;
        logic [31:0] d; int c, w0;
        cfg(4'hB);
        rd_cnt(32'h2000_04C8, d, c);
        chk("R11 alias read cost", c, 1);
        rd_cnt(32'h04C8, d, c);
        chk("R11 no allocation", c, 4);
        w0 = wr_cnt;
        access(1'b1, 32'h04C8, 32'hCAFE_0001, d);
        chk("R7 one memory write", wr_cnt - w0, 1);
        rd_cnt(32'h2000_04C8, d, c);
        chk("R7 memory updated", d, 32'hCAFE_0001);
        rd_cnt(32'h04C8, d, c);
        chk("R7 cache updated", d, 32'hCAFE_0001);
        chk("R7 still a hit", c, 0);
    endtask

    task automatic t_disabled;
        logic [31:0] d; int c, t0;
        cfg(4'h0);
        rd_cnt(32'h0138, d, c);
        chk("R12 read direct", c, 1);
        chk("R12 read data", d, pat(32'h138));
        t0 = txn;
        access(1'b1, 32'h0138, 32'h0000_7777, d);
        chk("R12 write direct", txn - t0, 1);
        rd_cnt(32'h0138, d, c);
        chk("R12 write reached memory", d, 32'h0000_7777);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 32'h5A00_0000 | i;
        repeat (3) @(posedge clk);
        #1 t_reset();
        rst_n = 1'b1;
        t_fill();
        t_alias();
        t_writeback();
        t_lru();
        t_lock();
        t_flush();
        t_wthru();
        t_disabled();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule